// File: doc/BRIEF.md
# Read-While-Program Bank Arbiter

This block sits in front of a 4M-word NOR array, 22-bit word address and 16-bit data. The array is split into four unequal banks. The block takes read, program and erase requests on one valid/ready stream. It decodes each word address into a bank and a sector from 0 to 141. The sector layout is asymmetric: there are small boot sectors at both ends of the address space and large sectors everywhere else. It tracks the single program/erase that may be in flight and applies hardware and per-sector write protection.

A read of any bank that is not busy goes straight to the array in the cycle it is accepted. A read of the busy bank never reaches the array; it is answered with a polling status word instead. At most two banks are active at any time: one busy with an embedded operation, and one being read. The embedded algorithm is modelled by a busy timer whose length comes from a configuration input. When the timer expires, the block drops back to plain read service without any command.

Back-pressure rule: there is one response slot. A request is accepted only when that slot is empty or is being drained in the same cycle. Program and erase requests use the same rule so that ordering stays simple. A response stays valid, with stable contents, until `rsp_ready` is seen high. Array read data is expected one cycle after `arr_rd_en` and must be held by the array until the next strobe.

Top module: `rwb_arbiter`

## Requirements
- R1: Bank decode on the word address: bank 0 covers addresses below 0x80000, bank 1 covers up to 0x1FFFFF, bank 2 covers up to 0x37FFFF, and bank 3 covers the rest. The bank is reported on `pe_bank` together with `pe_start`.
- R2: Sector decode, reported on `pe_sector`. Addresses below 0x8000 map to sector addr/4096 (sectors 0 to 7). Addresses at or above 0x3F8000 map to 134 + (addr-0x3F8000)/4096 (sectors 134 to 141). All other addresses map to 8 + (addr-0x8000)/32768.
- R3: A request with `req_op` 0 (read) or 3 (also a read) is accepted while `req_ready` is high. If its bank is not busy, `arr_rd_en` rises in that same cycle with `arr_rd_addr` equal to `req_addr`. The next cycle brings `rsp_valid` with `rsp_status`=0 and `rsp_data` equal to the array data.
- R4: A read whose bank is busy does not raise `arr_rd_en`. Its response has `rsp_status`=1 and carries a status word in `rsp_data`. Bit 7 of that word is the inverse of bit 7 of the target data. The target data is `req_data` for a program and all ones for an erase. Bit 6 is 0 on the first status read after an operation starts and inverts on every later status read. All other bits are 0.
- R5: A program (`req_op`=1) or erase (`req_op`=2) is started when it is accepted while the block is idle and the sector is unprotected. `pe_start` pulses for one cycle and `ry_by_n` goes low. `ry_by_n` stays low for exactly `cfg_pe_cycles` cycles (a value of 0 counts as 1) and then returns high on its own.
- R6: A program or erase accepted while another one is in progress is dropped. `busy_rej` pulses for one cycle, the running operation is unaffected, and no protect error is raised for it.
- R7: While `wp_n` is low, sectors 0, 1, 140 and 141 reject program and erase whatever the protection register holds.
- R8: The 142-bit protection register is written through `prot_wr`/`prot_sector`/`prot_set`; writes to sector numbers of 142 or more are ignored. Reset clears every bit. A program or erase aimed at a protected sector is dropped with a one-cycle `prot_err` pulse and `ry_by_n` stays high.
- R9: `req_ready` equals (not `rsp_valid`) or `rsp_ready`. A response held with `rsp_ready` low keeps `rsp_valid`, `rsp_status` and `rsp_data` unchanged.
- R10: During and right after reset, `ry_by_n` is 1, `rsp_valid` is 0, and `pe_start`, `prot_err` and `busy_rej` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 read |
| req_addr | input | 22 | Word address |
| req_data | input | 16 | Program data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 16 | Array data or status word |
| rsp_status | output | 1 | Response carries a status word |
| arr_rd_en | output | 1 | Array read strobe |
| arr_rd_addr | output | 22 | Array read address |
| arr_rd_data | input | 16 | Array data, one cycle after the strobe |
| wp_n | input | 1 | Hardware write protect of boot sectors, active low |
| prot_wr | input | 1 | Protection register write |
| prot_sector | input | 8 | Sector to write |
| prot_set | input | 1 | 1 protect, 0 unprotect |
| cfg_pe_cycles | input | 16 | Busy duration of one program/erase |
| pe_start | output | 1 | Pulse: operation started |
| pe_bank | output | 2 | Bank of the started operation |
| pe_sector | output | 8 | Sector of the started operation |
| ry_by_n | output | 1 | Ready/busy, low while busy |
| prot_err | output | 1 | Pulse: request hit a protected sector |
| busy_rej | output | 1 | Pulse: request refused because busy |

## Verification
The bench targets the decode edges: the last small and first large sector at the bottom, every bank boundary, and the first top small sector. A decoder that is one sector or one bank off reports the wrong `pe_sector` or `pe_bank` there. It polls the busy bank repeatedly after a program and after an erase. A design that reads the array instead, leaves the toggle bit uncleared, or inverts the wrong bit returns a wrong status word. It overlaps protection with busy, hardware protect, and register bits cleared by reset. A wrong priority or an unreset register then shows up as a start where an error pulse was due, or the reverse. Back-pressure stalls in the random phase catch a response that changes or is lost while held.

// File: rtl/rwb_pkg.sv
package rwb_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_READX = 2'd3
  } rwb_op_e;

  function automatic logic op_modifies(input logic [1:0] op);
    return (op == OP_PROG) || (op == OP_ERASE);
  endfunction

endpackage

// File: rtl/rwb_addr_map.sv
module rwb_addr_map #(
  parameter int unsigned ADDR_W  = 22,
  parameter int unsigned SMALL_W = 12,
  parameter int unsigned LARGE_W = 15,
  parameter int unsigned NBANK   = 4,
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned SEC_W   = 8,
  parameter int unsigned BANK_LG [NBANK] = '{16, 48, 48, 16}
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [SEC_W-1:0]  sector
);
  localparam int unsigned IDX_W     = ADDR_W - LARGE_W;
  localparam int unsigned SUB_W     = LARGE_W - SMALL_W;
  localparam int unsigned SM_PER_LG = 1 << SUB_W;
  localparam int unsigned TOTAL_LG  = 1 << IDX_W;
  localparam int unsigned TOP_BASE  = SM_PER_LG - 1 + TOTAL_LG - 1;

  function automatic int unsigned lg_end(input int b);
    int unsigned s;
    s = 0;
    for (int i = 0; i <= b; i++) s += BANK_LG[i];
    return s;
  endfunction

  logic [IDX_W-1:0] lg_idx;
  logic [SUB_W-1:0] sub_idx;
  logic [NBANK-2:0] past_end;

  assign lg_idx  = addr[ADDR_W-1:LARGE_W];
  assign sub_idx = addr[LARGE_W-1:SMALL_W];

  // one comparator per bank boundary; bank = boundaries passed
  for (genvar gb = 0; gb < NBANK - 1; gb++) begin : g_bnd
    localparam int unsigned END_LG = lg_end(gb);
    assign past_end[gb] = (32'(lg_idx) >= END_LG);
  end

  assign bank = BANK_W'($countones(past_end));

  // lowest and highest large slot are each split into small sectors
  always_comb begin
    if (lg_idx == '0)
      sector = SEC_W'(sub_idx);
    else if (lg_idx == IDX_W'(TOTAL_LG - 1))
      sector = SEC_W'(TOP_BASE) + SEC_W'(sub_idx);
    else
      sector = SEC_W'(lg_idx) + SEC_W'(SM_PER_LG - 1);
  end

endmodule

// File: rtl/rwb_protect.sv
module rwb_protect #(
  parameter int unsigned NSEC    = 142,
  parameter int unsigned SEC_W   = 8,
  parameter int unsigned BOOT_LO = 2,
  parameter int unsigned BOOT_HI = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [SEC_W-1:0] wr_sec,
  input  logic             wr_set,
  input  logic             wp_n,
  input  logic [SEC_W-1:0] chk_sec,
  output logic             locked
);
  logic [NSEC-1:0] bits_q;
  logic [NSEC-1:0] hard_mask;

  for (genvar gs = 0; gs < NSEC; gs++) begin : g_mask
    assign hard_mask[gs] = (gs < BOOT_LO) || (gs >= NSEC - BOOT_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (wr) begin
      for (int s = 0; s < NSEC; s++)
        if (wr_sec == SEC_W'(s)) bits_q[s] <= wr_set;
    end
  end

  logic in_range;
  assign in_range = (32'(chk_sec) < NSEC);

  always_comb begin
    locked = 1'b0;
    if (in_range)
      locked = bits_q[chk_sec] | (~wp_n & hard_mask[chk_sec]);
  end

endmodule

// File: rtl/rwb_pe_tracker.sv
module rwb_pe_tracker #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned POLL_BIT = 7,
  parameter int unsigned TOG_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BANK_W-1:0] start_bank,
  input  logic [DATA_W-1:0] start_target,
  input  logic [CNT_W-1:0]  cycles,
  input  logic              stat_rd,
  output logic              busy,
  output logic [BANK_W-1:0] busy_bank,
  output logic [DATA_W-1:0] stat_word
);
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic [BANK_W-1:0] bank_q;
  logic [DATA_W-1:0] tgt_q;
  logic              tog_q;
  logic [CNT_W-1:0]  load_val;

  assign load_val = (cycles == '0) ? CNT_W'(1) : cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      bank_q <= '0;
      tgt_q  <= '0;
    end else if (start) begin
      cnt_q  <= load_val;
      busy_q <= 1'b1;
      bank_q <= start_bank;
      tgt_q  <= start_target;
    end else if (busy_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tog_q <= 1'b0;
    else if (start)   tog_q <= 1'b0;
    else if (stat_rd) tog_q <= ~tog_q;
  end

  always_comb begin
    stat_word           = '0;
    stat_word[POLL_BIT] = ~tgt_q[POLL_BIT];
    stat_word[TOG_BIT]  = tog_q;
  end

  assign busy      = busy_q;
  assign busy_bank = bank_q;

endmodule

// File: rtl/rwb_arbiter.sv
module rwb_arbiter #(
  parameter int unsigned ADDR_W  = 22,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SMALL_W = 12,
  parameter int unsigned LARGE_W = 15,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NBANK   = 4,
  parameter int unsigned BANK_LG [NBANK] = '{16, 48, 48, 16},
  parameter int unsigned SEC_W   = 8,
  parameter int unsigned BANK_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_status,
  output logic              arr_rd_en,
  output logic [ADDR_W-1:0] arr_rd_addr,
  input  logic [DATA_W-1:0] arr_rd_data,
  input  logic              wp_n,
  input  logic              prot_wr,
  input  logic [SEC_W-1:0]  prot_sector,
  input  logic              prot_set,
  input  logic [CNT_W-1:0]  cfg_pe_cycles,
  output logic              pe_start,
  output logic [BANK_W-1:0] pe_bank,
  output logic [SEC_W-1:0]  pe_sector,
  output logic              ry_by_n,
  output logic              prot_err,
  output logic              busy_rej
);
  import rwb_pkg::*;

  localparam int unsigned SM_PER_LG = 1 << (LARGE_W - SMALL_W);
  localparam int unsigned TOTAL_LG  = 1 << (ADDR_W - LARGE_W);
  localparam int unsigned NSEC      = TOTAL_LG - 2 + 2 * SM_PER_LG;

  logic [BANK_W-1:0] req_bank;
  logic [SEC_W-1:0]  req_sec;
  logic              sec_locked;
  logic              trk_busy;
  logic [BANK_W-1:0] trk_bank;
  logic [DATA_W-1:0] trk_word;

  rwb_addr_map #(
    .ADDR_W(ADDR_W), .SMALL_W(SMALL_W), .LARGE_W(LARGE_W),
    .NBANK(NBANK), .BANK_W(BANK_W), .SEC_W(SEC_W), .BANK_LG(BANK_LG)
  ) u_map (
    .addr(req_addr), .bank(req_bank), .sector(req_sec)
  );

  rwb_protect #(.NSEC(NSEC), .SEC_W(SEC_W)) u_prot (
    .clk(clk), .rst_n(rst_n),
    .wr(prot_wr), .wr_sec(prot_sector), .wr_set(prot_set),
    .wp_n(wp_n), .chk_sec(req_sec), .locked(sec_locked)
  );

  // request classification
  logic rsp_valid_q, rsp_stat_q;
  logic [DATA_W-1:0] rsp_word_q;
  logic accept, is_mod, do_read, do_mod, hits_busy, stat_rd, start_op;
  logic [DATA_W-1:0] target;

  assign req_ready = ~rsp_valid_q | rsp_ready;
  assign accept    = req_valid & req_ready;
  assign is_mod    = op_modifies(req_op);
  assign do_read   = accept & ~is_mod;
  assign do_mod    = accept & is_mod;
  assign hits_busy = trk_busy & (req_bank == trk_bank);
  assign stat_rd   = do_read & hits_busy;
  assign start_op  = do_mod & ~trk_busy & ~sec_locked;
  assign target    = (req_op == OP_ERASE) ? '1 : req_data;

  assign arr_rd_en   = do_read & ~hits_busy;
  assign arr_rd_addr = req_addr;

  rwb_pe_tracker #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .BANK_W(BANK_W)
  ) u_trk (
    .clk(clk), .rst_n(rst_n),
    .start(start_op), .start_bank(req_bank), .start_target(target),
    .cycles(cfg_pe_cycles), .stat_rd(stat_rd),
    .busy(trk_busy), .busy_bank(trk_bank), .stat_word(trk_word)
  );

  // single response slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_stat_q  <= 1'b0;
      rsp_word_q  <= '0;
    end else if (do_read) begin
      rsp_valid_q <= 1'b1;
      rsp_stat_q  <= hits_busy;
      rsp_word_q  <= trk_word;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_status = rsp_stat_q;
  assign rsp_data   = rsp_stat_q ? rsp_word_q : arr_rd_data;

  // event pulses
  logic              start_q, perr_q, rej_q;
  logic [BANK_W-1:0] pbank_q;
  logic [SEC_W-1:0]  psec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      perr_q  <= 1'b0;
      rej_q   <= 1'b0;
      pbank_q <= '0;
      psec_q  <= '0;
    end else begin
      start_q <= start_op;
      perr_q  <= do_mod & ~trk_busy & sec_locked;
      rej_q   <= do_mod & trk_busy;
      if (start_op) begin
        pbank_q <= req_bank;
        psec_q  <= req_sec;
      end
    end
  end

  assign pe_start  = start_q;
  assign pe_bank   = pbank_q;
  assign pe_sector = psec_q;
  assign prot_err  = perr_q;
  assign busy_rej  = rej_q;
  assign ry_by_n   = ~trk_busy;

endmodule

// File: rtl/rwb_arbiter_chk.sv
module rwb_arbiter_chk #(
  parameter int unsigned NSEC   = 142,
  parameter int unsigned SEC_W  = 8,
  parameter int unsigned BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pe_start,
  input logic              ry_by_n,
  input logic              prot_err,
  input logic              busy_rej,
  input logic              arr_rd_en,
  input logic [BANK_W-1:0] req_bank,
  input logic [BANK_W-1:0] busy_bank,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [SEC_W-1:0]  pe_sector,
  input logic              wp_n
);
  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_start |-> !ry_by_n);

  // R5
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ry_by_n) |-> pe_start);

  // R6
  start_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_start |-> (!prot_err && !busy_rej));

  // R4
  busy_bank_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd_en && !ry_by_n) |-> (req_bank != busy_bank));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid);

  // R2
  sector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_start |-> (32'(pe_sector) < NSEC));

  // R7
  boot_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_start && $past(!wp_n)) |->
      !((32'(pe_sector) < 2) || (32'(pe_sector) >= NSEC - 2)));

endmodule

bind rwb_arbiter rwb_arbiter_chk #(
  .NSEC(NSEC), .SEC_W(SEC_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pe_start(pe_start), .ry_by_n(ry_by_n),
  .prot_err(prot_err), .busy_rej(busy_rej), .arr_rd_en(arr_rd_en),
  .req_bank(req_bank), .busy_bank(trk_bank), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .pe_sector(pe_sector), .wp_n(wp_n)
);

// File: tb/rwb_arbiter_tb.sv
`timescale 1ns/1ps
module rwb_arbiter_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_op = 0;
  logic [21:0] req_addr = 0;
  logic [15:0] req_data = 0;
  logic rsp_valid, rsp_ready = 1, rsp_status;
  logic [15:0] rsp_data;
  logic arr_rd_en;
  logic [21:0] arr_rd_addr;
  logic [15:0] arr_q = 0;
  logic wp_n = 1, prot_wr = 0, prot_set = 0;
  logic [7:0] prot_sector = 0;
  logic [15:0] cfg_pe_cycles = 4;
  logic pe_start, ry_by_n, prot_err, busy_rej;
  logic [1:0] pe_bank;
  logic [7:0] pe_sector;

  always #2.5 clk = ~clk;

  rwb_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_status(rsp_status), .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr),
    .arr_rd_data(arr_q), .wp_n(wp_n), .prot_wr(prot_wr),
    .prot_sector(prot_sector), .prot_set(prot_set),
    .cfg_pe_cycles(cfg_pe_cycles), .pe_start(pe_start), .pe_bank(pe_bank),
    .pe_sector(pe_sector), .ry_by_n(ry_by_n), .prot_err(prot_err),
    .busy_rej(busy_rej)
  );

  function automatic logic [15:0] mem_fn(input logic [21:0] a);
    return a[15:0] ^ {a[21:16], 10'h2A5};
  endfunction

  // array model: data one cycle after the strobe, held until next strobe
  always @(posedge clk) if (arr_rd_en) arr_q <= mem_fn(arr_rd_addr);

  function automatic int f_bank(input int a);
    if (a < 'h80000) return 0;
    if (a < 'h200000) return 1;
    if (a < 'h380000) return 2;
    return 3;
  endfunction

  function automatic int f_sector(input int a);
    if (a < 'h8000) return a / 4096;
    if (a >= 'h3F8000) return 134 + (a - 'h3F8000) / 4096;
    return 8 + (a - 'h8000) / 32768;
  endfunction

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // reference model state
  bit m_busy, m_tog, m_rv, m_rstat;
  int m_cnt, m_bank;
  logic [15:0] m_tgt, m_rdata;
  bit m_prot [142];

  task automatic model_clear();
    m_busy = 0; m_tog = 0; m_rv = 0; m_rstat = 0; m_cnt = 0; m_bank = 0;
    m_tgt = 0; m_rdata = 0;
    foreach (m_prot[i]) m_prot[i] = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; req_valid = 0; prot_wr = 0; rsp_ready = 1;
    repeat (2) @(posedge clk);
    #1;
    // R10
    chk("R10", ry_by_n, 1, "ry_by_n in reset");
    chk("R10", rsp_valid, 0, "rsp_valid in reset");
    chk("R10", pe_start | prot_err | busy_rej, 0, "pulses in reset");
    model_clear();
    rst_n = 1;
  endtask

  task automatic step();
    bit acc, rd, wr, hit, lk, st, pe, rj, rdy;
    int sec, bk;
    logic [15:0] sw;
    sec = f_sector(int'(req_addr));
    bk  = f_bank(int'(req_addr));
    rdy = rsp_ready;
    #0.5;
    chk("R9", req_ready, (!m_rv || rdy), "req_ready");
    acc = req_valid && (!m_rv || rdy);
    wr  = acc && (req_op == 1 || req_op == 2);
    rd  = acc && !wr;
    hit = m_busy && (bk == m_bank);
    chk(hit ? "R4" : "R3", arr_rd_en, rd && !hit, "arr_rd_en");
    if (rd && !hit) chk("R3", arr_rd_addr, req_addr, "arr_rd_addr");
    lk = m_prot[sec] || (!wp_n && (sec < 2 || sec > 139));
    rj = wr && m_busy;
    pe = wr && !m_busy && lk;
    st = wr && !m_busy && !lk;
    sw = 16'h0;
    sw[7] = ~m_tgt[7];
    sw[6] = m_tog;
    @(posedge clk);
    #1;
    if (rd) begin
      m_rv = 1; m_rstat = hit;
      m_rdata = hit ? sw : mem_fn(req_addr);
      if (hit) m_tog = !m_tog;
    end else if (rdy) m_rv = 0;
    if (st) begin
      m_busy = 1; m_cnt = (cfg_pe_cycles == 0) ? 1 : int'(cfg_pe_cycles);
      m_bank = bk; m_tgt = (req_op == 2) ? 16'hFFFF : req_data; m_tog = 0;
    end else if (m_busy) begin
      if (m_cnt == 1) m_busy = 0;
      m_cnt--;
    end
    if (prot_wr && prot_sector < 142) m_prot[prot_sector] = prot_set;
    chk("R5", ry_by_n, !m_busy, "ry_by_n");
    chk("R5", pe_start, st, "pe_start");
    if (st) begin
      chk("R1", pe_bank, bk, "pe_bank");
      chk("R2", pe_sector, sec, "pe_sector");
    end
    chk((!wp_n && (sec < 2 || sec > 139)) ? "R7" : "R8", prot_err, pe, "prot_err");
    chk("R6", busy_rej, rj, "busy_rej");
    chk("R9", rsp_valid, m_rv, "rsp_valid");
    if (m_rv) begin
      chk("R4", rsp_status, m_rstat, "rsp_status");
      chk(m_rstat ? "R4" : "R3", rsp_data, m_rdata, "rsp_data");
    end
  endtask

  task automatic idle(input int n);
    req_valid = 0; prot_wr = 0;
    repeat (n) step();
  endtask

  task automatic req(input int op, input int addr, input int data);
    req_valid = 1; req_op = 2'(op); req_addr = 22'(addr); req_data = 16'(data);
    prot_wr = 0;
    step();
    req_valid = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 70000 && m_busy; i++) idle(1);
  endtask

  task automatic prot_write(input int s, input bit v);
    req_valid = 0; prot_wr = 1; prot_sector = 8'(s); prot_set = v;
    step();
    prot_wr = 0;
  endtask

  int edges [11] = '{'h7FFF, 'h8000, 'h7FFFF, 'h80000, 'h1FFFFF, 'h200000,
                     'h37FFFF, 'h380000, 'h3F7FFF, 'h3F8000, 'h3FFFFF};

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    void'($urandom(32'd1234));
    do_reset();
    idle(2);
    // R3 plain read while idle
    req(0, 'h1234, 0);
    req(3, 'h2A0001, 0);
    idle(1);
    // R5 program in bank 0, R4 polling, R3 read of other bank, R6 reject
    cfg_pe_cycles = 6;
    req(1, 'h0010, 'h0080);
    req(0, 'h0100, 0);
    req(0, 'h7FFFF, 0);
    req(0, 'h250000, 0);
    req(2, 'h250000, 0);
    req(0, 'h0200, 0);
    wait_idle();
    req(0, 'h0100, 0);
    // R5 zero duration counts as one
    cfg_pe_cycles = 0;
    req(1, 'h90000, 'h0001);
    idle(2);
    // R7 boot lock
    cfg_pe_cycles = 3;
    wp_n = 0;
    req(1, 'h1000, 1);
    req(2, 'h3FF000, 0);
    req(2, 'h0000, 0);
    req(1, 'h3FD000, 5);
    wait_idle();
    wp_n = 1;
    req(1, 'h1000, 1);
    wait_idle();
    // R8 register protection
    prot_write(60, 1);
    prot_write(200, 1);
    req(1, 'h1A8000, 3);
    req(1, 'h1A0000, 3);
    wait_idle();
    prot_write(60, 0);
    req(1, 'h1A8000, 3);
    wait_idle();
    // R4 erase status in bank 3
    req(2, 'h3C0000, 0);
    req(0, 'h3FFFFF, 0);
    req(0, 'h380000, 0);
    wait_idle();
    // R1 R2 boundary decode
    cfg_pe_cycles = 1;
    foreach (edges[i]) begin
      req(1, edges[i], i);
      idle(1);
    end
    // R8 reset clears protection
    prot_write(60, 1);
    do_reset();
    req(1, 'h1A8000, 3);
    wait_idle();
    // R9 back-pressure
    rsp_ready = 0;
    req(0, 'h4444, 0);
    req(0, 'h5555, 0);
    idle(2);
    rsp_ready = 1;
    req(0, 'h5555, 0);
    idle(1);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      req_valid = (r < 70);
      r = int'($urandom_range(0, 9));
      req_op = (r < 6) ? 2'd0 : (r < 8) ? 2'd1 : (r < 9) ? 2'd2 : 2'd3;
      if ($urandom_range(0, 2) == 0) req_addr = 22'(edges[$urandom_range(0, 10)]);
      else req_addr = 22'($urandom);
      req_data = 16'($urandom);
      rsp_ready = ($urandom_range(0, 3) != 0);
      prot_wr = ($urandom_range(0, 19) == 0);
      prot_sector = 8'($urandom_range(0, 150));
      prot_set = 1'($urandom);
      if ($urandom_range(0, 49) == 0) wp_n = ~wp_n;
      if ($urandom_range(0, 29) == 0) cfg_pe_cycles = 16'($urandom_range(0, 12));
      step();
    end
    idle(20);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule